// File: doc/BRIEF.md
# Programmable Even Clock Divider

This block produces a core clock from an oscillator clock. The ratio is twice an 8-bit divisor value N. For N from 1 to 255 the output is a square wave with a period of 2N oscillator cycles and a 50% duty cycle. For N equal to zero the oscillator clock passes straight to the output. Software may rewrite the divisor at any moment. A change always waits for an output period boundary, and the switch into or out of pass-through mode happens only while both clocks are low, so the output never shows a runt pulse.

Next to the clock the block drives a clock-enable that is high for one oscillator cycle at each rising edge of the output. Downstream logic that runs on the oscillator clock can use it in place of the divided clock. A low-power select flag sits beside the divisor. It is cleared by reset and changes only through its own write strobe.

Top module: `clkdiv_even`

## Requirements
- R1: While `rst` is high, and after it is released, `core_clk_en` reads 0 during reset, `lp_sel` is 0, and the divisor is 0, so the block starts in pass-through mode.
- R2: With an active divisor N of 1 or more, `core_clk` stays high for exactly N `osc_clk` cycles and then low for exactly N cycles.
- R3: In divided mode `core_clk_en` is high for exactly one `osc_clk` cycle per output period, and that cycle is the first cycle in which `core_clk` is high.
- R4: With a divisor of 0, `core_clk` follows `osc_clk` (high in the first half of each cycle, low in the second) and `core_clk_en` stays at 1.
- R5: A divisor written during divided operation is used only from the next rising edge of `core_clk`. The period in progress finishes both of its halves at the old ratio.
- R6: The output source changes only while both `osc_clk` and the divided level are low. When leaving divided mode for pass-through, the last low phase lasts N+1 cycles. When entering divided mode, the first high phase from the divider lasts a full N cycles.
- R7: `lp_sel` takes `lp_wdata` only on a cycle with `lp_wr` high. Divisor writes leave it unchanged, and reset clears it to 0.
- R8: A divisor of 255 gives the largest ratio, 510: 255 cycles high and 255 cycles low.
- R9: A divisor of 1 gives a ratio of 2: the output toggles on every `osc_clk` rising edge, and `core_clk_en` is high every second cycle.
- R10: When several divisor writes land before one period boundary, only the last written value takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock; every register except the source select uses its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| div_wr | input | 1 | Write strobe for the divisor |
| div_wdata | input | 8 | Divisor value N to be written |
| lp_wr | input | 1 | Write strobe for the low-power flag |
| lp_wdata | input | 1 | Value to be written to the low-power flag |
| core_clk | output | 1 | Divided core clock, or `osc_clk` when N is 0 |
| core_clk_en | output | 1 | One-cycle enable marking each `core_clk` rising edge |
| lp_sel | output | 1 | Low-power select flag |

## Verification
Some properties are checked on every cycle. The half-period counter stays below the active ratio. The enable follows the rising edges of the divider, and it is held high in pass-through mode. The active ratio is frozen everywhere except at a rising boundary. The output source flips only while the divided level is low. The low-power flag stays unchanged without its strobe. Other behaviour shows only in the bench's scenarios: the exact lengths of the high and low phases for each divisor, the N+1 low phase when entering pass-through, the full first high phase after leaving it, the deferral of a mid-period update, and the last-write-wins rule.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // Output source selection
  typedef enum logic {
    OUT_PASS = 1'b0,
    OUT_DIV  = 1'b1
  } out_src_e;

endpackage

// File: rtl/div_cfg_regs.sv
module div_cfg_regs #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  input  logic             lp_wr,
  input  logic             lp_wdata,
  output logic [DIV_W-1:0] pend_o,
  output logic             lp_o
);

  logic [DIV_W-1:0] pend_q;
  logic             lp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      lp_q   <= 1'b0;
    end else begin
      if (div_wr) pend_q <= div_wdata;
      if (lp_wr)  lp_q   <= lp_wdata;
    end
  end

  assign pend_o = pend_q;
  assign lp_o   = lp_q;

  AST_LP_HOLD: assert property (@(posedge clk) disable iff (rst) !lp_wr |=> $stable(lp_q)); // R7
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst) !div_wr |=> $stable(pend_q)); // R10

endmodule

// File: rtl/div_half_timer.sv
module div_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] pend_i,
  output logic             div_o,
  output logic             mode_o,
  output logic             en_o
);

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] ratio_q, ratio_n;
  logic [DIV_W-1:0] cnt_q, cnt_n;
  logic             div_q, div_n;
  logic             mode_q, mode_n;
  logic             en_q, en_n;
  logic             last;

  assign last = (cnt_q == ratio_q - ONE);

  always_comb begin
    ratio_n = ratio_q;
    cnt_n   = cnt_q;
    div_n   = div_q;
    mode_n  = mode_q;
    if (!mode_q) begin
      // pass-through: leave it as soon as a nonzero divisor is pending
      if (pend_i != '0) begin
        mode_n  = 1'b1;
        ratio_n = pend_i;
        cnt_n   = '0;
        div_n   = 1'b0;
      end
    end else if (last) begin
      cnt_n = '0;
      if (div_q) begin
        div_n = 1'b0;
      end else if (pend_i == '0) begin
        mode_n = 1'b0;
        div_n  = 1'b0;
      end else begin
        div_n   = 1'b1;
        ratio_n = pend_i;
      end
    end else begin
      cnt_n = cnt_q + ONE;
    end
    en_n = !mode_q || (div_n && !div_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_q <= '0;
      cnt_q   <= '0;
      div_q   <= 1'b0;
      mode_q  <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      ratio_q <= ratio_n;
      cnt_q   <= cnt_n;
      div_q   <= div_n;
      mode_q  <= mode_n;
      en_q    <= en_n;
    end
  end

  assign div_o  = div_q;
  assign mode_o = mode_q;
  assign en_o   = en_q;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst) mode_q |-> (ratio_q != '0 && cnt_q < ratio_q)); // R2
  AST_EN_AT_RISE: assert property (@(posedge clk) disable iff (rst) (mode_q && !div_q) |=> (en_q == div_q)); // R3
  AST_EN_LOW_IN_HIGH: assert property (@(posedge clk) disable iff (rst) (mode_q && div_q) |=> !en_q); // R3
  AST_PASS_EN: assert property (@(posedge clk) disable iff (rst) !mode_q |=> en_q); // R4
  AST_RATIO_FROZEN: assert property (@(posedge clk) disable iff (rst) (mode_q && (div_q || !last)) |=> $stable(ratio_q)); // R5
  AST_PASS_DIV_LOW: assert property (@(posedge clk) disable iff (rst) !mode_q |-> !div_q); // R6

endmodule

// File: rtl/div_out_select.sv
module div_out_select
  import clkdiv_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic div_i,
  input  logic mode_i,
  output logic clk_o
);

  out_src_e sel_q;

  // updated on the falling edge, and only while the divided level is low
  always_ff @(negedge clk) begin
    if (rst) begin
      sel_q <= OUT_PASS;
    end else if (!div_i) begin
      sel_q <= mode_i ? OUT_DIV : OUT_PASS;
    end
  end

  assign clk_o = (sel_q == OUT_DIV) ? div_i : clk;

  AST_SEL_SWITCH_LOW: assert property (@(negedge clk) disable iff (rst) !$stable(sel_q) |-> !$past(div_i)); // R6

endmodule

// File: rtl/clkdiv_even.sv
module clkdiv_even #(
  parameter int DIV_W = 8
) (
  input  logic             osc_clk,
  input  logic             rst,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  input  logic             lp_wr,
  input  logic             lp_wdata,
  output logic             core_clk,
  output logic             core_clk_en,
  output logic             lp_sel
);

  logic [DIV_W-1:0] pend;
  logic             div_lvl;
  logic             div_mode;

  div_cfg_regs #(.DIV_W(DIV_W)) u_regs (
    .clk       (osc_clk),
    .rst       (rst),
    .div_wr    (div_wr),
    .div_wdata (div_wdata),
    .lp_wr     (lp_wr),
    .lp_wdata  (lp_wdata),
    .pend_o    (pend),
    .lp_o      (lp_sel)
  );

  div_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk    (osc_clk),
    .rst    (rst),
    .pend_i (pend),
    .div_o  (div_lvl),
    .mode_o (div_mode),
    .en_o   (core_clk_en)
  );

  div_out_select u_sel (
    .clk    (osc_clk),
    .rst    (rst),
    .div_i  (div_lvl),
    .mode_i (div_mode),
    .clk_o  (core_clk)
  );

endmodule

// File: tb/clkdiv_even_bench.sv
module clkdiv_even_bench;

  logic       osc_clk = 1'b0;
  logic       rst = 1'b1;
  logic       div_wr = 1'b0;
  logic [7:0] div_wdata = '0;
  logic       lp_wr = 1'b0;
  logic       lp_wdata = 1'b0;
  logic       core_clk;
  logic       core_clk_en;
  logic       lp_sel;

  int  n_tests = 0;
  int  n_fail = 0;
  bit  done = 0;
  logic cur = 1'b0, prev = 1'b0, cur_en = 1'b0;
  int  en_hits = 0;

  // columns: divisor, expected high cycles, expected low cycles
  localparam int NV = 6;
  localparam int VEC [NV][3] = '{'{1, 1, 1}, '{2, 2, 2}, '{3, 3, 3},
                                 '{7, 7, 7}, '{16, 16, 16}, '{255, 255, 255}};

  clkdiv_even u_clkdiv_even (
    .osc_clk     (osc_clk),
    .rst         (rst),
    .div_wr      (div_wr),
    .div_wdata   (div_wdata),
    .lp_wr       (lp_wr),
    .lp_wdata    (lp_wdata),
    .core_clk    (core_clk),
    .core_clk_en (core_clk_en),
    .lp_sel      (lp_sel)
  );

  always #4 osc_clk = ~osc_clk;

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one sample, 2 ns after a rising edge
  task automatic step();
    @(posedge osc_clk);
    #2;
    prev   = cur;
    cur    = core_clk;
    cur_en = core_clk_en;
  endtask

  task automatic wait_rise();
    int guard = 0;
    step();
    while (!(cur && !prev) && guard < 2000) begin
      step();
      guard++;
    end
    if (guard >= 2000) check("R2 rising edge seen", 0, 1);
  endtask

  task automatic run_len(input logic lvl, output int n);
    n = 0;
    while (cur == lvl && n < 1000) begin
      n++;
      if (cur_en) en_hits++;
      step();
    end
  endtask

  task automatic measure(output int h, output int l, output int e);
    wait_rise();
    en_hits = 0;
    run_len(1'b1, h);
    run_len(1'b0, l);
    e = en_hits;
  endtask

  task automatic write_div(input int v);
    div_wdata = 8'(v);
    div_wr = 1'b1;
    fork
      begin
        @(posedge osc_clk);
        #1 div_wr = 1'b0;
      end
    join_none
  endtask

  initial begin
    int h, l, e, h2, l2;
    string tag;

    // reset state
    repeat (4) @(posedge osc_clk);
    #2;
    check("R1 enable during reset", int'(core_clk_en), 0);
    check("R1 lp_sel during reset", int'(lp_sel), 0);
    rst = 1'b0;
    step();
    step();
    check("R1 pass-through after reset (high half)", int'(cur), 1);
    check("R1 enable after reset", int'(cur_en), 1);
    #4;
    check("R4 pass-through low half", int'(core_clk), 0);

    // table of divisors
    for (int i = 0; i < NV; i++) begin
      tag = (VEC[i][0] == 255) ? "R8" : ((VEC[i][0] == 1) ? "R9" : "R2");
      write_div(VEC[i][0]);
      measure(h, l, e);
      measure(h, l, e);
      check({tag, " high cycles"}, h, VEC[i][1]);
      check({tag, " low cycles"}, l, VEC[i][2]);
      check("R3 enables per period", e, 1);
    end

    // mid-period update
    write_div(3);
    measure(h, l, e);
    wait_rise();
    check("R3 enable on rising sample", int'(cur_en), 1);
    write_div(5);
    run_len(1'b1, h);
    run_len(1'b0, l);
    run_len(1'b1, h2);
    run_len(1'b0, l2);
    check("R5 old high kept", h, 3);
    check("R5 old low kept", l, 3);
    check("R5 new high", h2, 5);
    check("R5 new low", l2, 5);

    // several writes before one boundary
    wait_rise();
    write_div(6);
    step();
    write_div(2);
    measure(h, l, e);
    measure(h, l, e);
    check("R10 last write high", h, 2);
    check("R10 last write low", l, 2);

    // leave divided mode for pass-through
    wait_rise();
    write_div(0);
    run_len(1'b1, h);
    run_len(1'b0, l);
    check("R6 last high before pass-through", h, 2);
    check("R6 stretched last low", l, 3);
    check("R4 first pass-through high", int'(cur), 1);
    check("R4 first pass-through enable", int'(cur_en), 1);
    for (int k = 0; k < 8; k++) begin
      #4;
      check("R4 follows osc low half", int'(core_clk), 0);
      step();
      check("R4 follows osc high half", int'(cur), 1);
      check("R4 enable held", int'(cur_en), 1);
    end

    // enter divided mode from pass-through
    write_div(3);
    wait_rise();
    run_len(1'b1, h);
    run_len(1'b0, l);
    check("R6 first divided high", h, 3);
    check("R6 first divided low", l, 3);

    // low-power flag
    lp_wdata = 1'b1;
    lp_wr = 1'b1;
    step();
    lp_wr = 1'b0;
    check("R7 lp set by write", int'(lp_sel), 1);
    write_div(7);
    step();
    step();
    check("R7 lp kept over divisor write", int'(lp_sel), 1);
    lp_wdata = 1'b0;
    step();
    check("R7 lp kept without strobe", int'(lp_sel), 1);
    lp_wr = 1'b1;
    step();
    lp_wr = 1'b0;
    check("R7 lp cleared by write", int'(lp_sel), 0);
    lp_wdata = 1'b1;
    lp_wr = 1'b1;
    step();
    lp_wr = 1'b0;
    rst = 1'b1;
    step();
    step();
    check("R7 lp cleared by reset", int'(lp_sel), 0);
    check("R1 enable low in reset", int'(core_clk_en), 0);
    rst = 1'b0;
    step();
    step();
    check("R1 pass-through after second reset", int'(cur), 1);
    check("R1 enable after second reset", int'(cur_en), 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog R1 actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule